// File: doc/BRIEF.md
# Four-Lane Seven-Bit Serial-to-Parallel Frame Expander

This block is the digital back end of a source-synchronous link receiver. Four serial data lanes arrive alongside a forwarded slow frame clock. The block runs on a bit clock at seven times the frame rate. That bit clock is supplied already phase aligned, and a one-cycle frame strobe is derived from the slow clock. Each lane fills its own seven-bit shift register. Once seven bits have been taken after the strobe, all lanes are moved together into a 28-bit output register.

The block also produces an output clock for the parallel bus. Each pulse of that clock starts on the edge that loads a new word, and it falls while the word is still held, so a downstream stage can sample on the falling edge. An active-low shutdown input clears every register at once and holds the output clock low. A narrow mode uses only three lanes and yields a 21-bit word. In that mode the upper field reads zero and the fourth lane is ignored.

Top module: `serial_frame_expander`

## Requirements
- R1: While `shut_n` is low, every register is cleared asynchronously: `par_out` reads 0 and `clk_out` reads 0, independent of the other inputs.
- R2: On the bit-clock edge where `frame_start` is 1, the first bit of the slot is sampled on every lane, and the next six edges sample the remaining six bits. The first bit lands in the least significant position of its lane field. Lane k fills `par_out[7k+6:7k]`.
- R3: `par_out` takes the new word on the eighth bit-clock edge of a slot (counting the `frame_start` edge as the first), and it changes at no other edge.
- R4: `clk_out` stays low for the whole time `shut_n` is low.
- R5: `clk_out` rises on the edge that loads `par_out` and stays high for four bit-clock cycles. It falls on the fourth edge after the load, and `par_out` does not change across that falling edge.
- R6: The value of `mode_narrow` on the `frame_start` edge applies to that slot. When it is 1, `par_out[27:21]` is loaded with 0 and `lane_in[3]` has no effect on the word.
- R7: After `shut_n` is released, `par_out` stays 0 and `clk_out` stays low until a full slot has been received after a `frame_start`.
- R8: A `frame_start` that arrives before seven bits have been taken restarts the slot. The partial bits never reach `par_out`, and the word that is loaded comes entirely from the restarted slot.
- R9: Slots may follow each other with no gap (one strobe every seven bit-clock cycles) or with idle cycles between them. Bits that arrive after the seventh and before the next `frame_start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the frame rate |
| shut_n | input | 1 | Active-low shutdown and asynchronous clear |
| frame_start | input | 1 | One-cycle strobe marking the first bit of a slot |
| mode_narrow | input | 1 | 1 selects the three-lane, 21-bit mode |
| lane_in | input | 4 | Serial data, one bit per lane |
| par_out | output | 28 | Parallel word, valid across the falling edge of clk_out |
| clk_out | output | 1 | Output clock for the parallel bus |

## Verification
A slot counter that is off by one shows up at the ports within one slot: the load moves a cycle early or late, and every lane field comes out rotated by one bit. A wrong lane enable, or a mode latched at the wrong time, shows up as junk in bits 27:21 on the first narrow slot, or as a stale field after returning to four lanes. A clock-pulse counter that runs too long or too short shifts the falling edge of `clk_out` in the first pulse after any load. A register left out of the clear leaks a nonzero value before the first complete slot that follows a shutdown.

// File: rtl/serx_pkg.sv
package serx_pkg;

  // 1 when a lane takes part in the current slot
  function automatic logic lane_enabled(int unsigned lane,
                                        int unsigned narrow_lanes,
                                        logic        narrow);
    return (lane < narrow_lanes) || !narrow;
  endfunction

  // lowest output bit of a lane field
  function automatic int unsigned field_base(int unsigned lane,
                                             int unsigned slot_bits);
    return lane * slot_bits;
  endfunction

endpackage

// File: rtl/serx_lane_shift.sv
module serx_lane_shift #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] field
);
  logic [W-1:0] sr_q;

  // newest bit enters at the top, so after W shifts the first bit sits at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {din, sr_q[W-1:1]};
  end

  assign field = sr_q;
endmodule

// File: rtl/serx_slot_ctrl.sv
module serx_slot_ctrl #(
  parameter int unsigned SLOT_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic narrow_in,
  output logic shift_en,
  output logic lane_narrow,
  output logic frame_narrow,
  output logic xfer
);
  localparam int unsigned CW = $clog2(SLOT_BITS + 1);

  logic [CW-1:0] cnt_q;
  logic          narrow_q;

  always_comb begin
    xfer         = (cnt_q == CW'(SLOT_BITS));
    shift_en     = frame_start || ((cnt_q != '0) && (cnt_q < CW'(SLOT_BITS)));
    lane_narrow  = frame_start ? narrow_in : narrow_q;
    frame_narrow = narrow_q;
  end

  // cnt_q counts bits taken in the slot; 0 means idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      narrow_q <= 1'b0;
    end else if (frame_start) begin
      cnt_q    <= CW'(1);
      narrow_q <= narrow_in;
    end else if (xfer) begin
      cnt_q    <= '0;
    end else if (cnt_q != '0) begin
      cnt_q    <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/serx_clk_gen.sv
module serx_clk_gen #(
  parameter int unsigned HIGH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  output logic clk_out
);
  localparam int unsigned HW = $clog2(HIGH_CYC + 1);

  logic [HW-1:0] hc_q;
  logic          ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= 1'b0;
      hc_q <= '0;
    end else if (xfer) begin
      ck_q <= 1'b1;
      hc_q <= HW'(1);
    end else if (ck_q) begin
      if (hc_q == HW'(HIGH_CYC)) begin
        ck_q <= 1'b0;
        hc_q <= '0;
      end else begin
        hc_q <= hc_q + HW'(1);
      end
    end
  end

  assign clk_out = ck_q;
endmodule

// File: rtl/serial_frame_expander.sv
module serial_frame_expander #(
  parameter int unsigned LANES        = 4,
  parameter int unsigned SLOT_BITS    = 7,
  parameter int unsigned NARROW_LANES = 3,
  parameter int unsigned CLK_HIGH_CYC = 4
) (
  input  logic                         clk_bit,
  input  logic                         shut_n,
  input  logic                         frame_start,
  input  logic                         mode_narrow,
  input  logic [LANES-1:0]             lane_in,
  output logic [LANES*SLOT_BITS-1:0]   par_out,
  output logic                         clk_out
);
  import serx_pkg::*;

  localparam int unsigned WORD_W   = LANES * SLOT_BITS;
  localparam int unsigned NARROW_W = NARROW_LANES * SLOT_BITS;
  // the pulse must end before the earliest next load
  localparam int unsigned HIGH_EFF = (CLK_HIGH_CYC == 0) ? 1 :
                                     (CLK_HIGH_CYC >= SLOT_BITS) ? SLOT_BITS - 1 :
                                     CLK_HIGH_CYC;

  // named internal events
  logic              shift_en_w;
  logic              lane_narrow_w;
  logic              frame_narrow_w;
  logic              xfer_w;
  logic [WORD_W-1:0] word_next_w;
  logic [WORD_W-1:0] par_q;

  serx_slot_ctrl #(.SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk          (clk_bit),
    .rst_n        (shut_n),
    .frame_start  (frame_start),
    .narrow_in    (mode_narrow),
    .shift_en     (shift_en_w),
    .lane_narrow  (lane_narrow_w),
    .frame_narrow (frame_narrow_w),
    .xfer         (xfer_w)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic                 en_k;
    logic [SLOT_BITS-1:0] field_k;

    assign en_k = shift_en_w && lane_enabled(k, NARROW_LANES, lane_narrow_w);

    serx_lane_shift #(.W(SLOT_BITS)) u_shift (
      .clk      (clk_bit),
      .rst_n    (shut_n),
      .shift_en (en_k),
      .din      (lane_in[k]),
      .field    (field_k)
    );

    assign word_next_w[field_base(k, SLOT_BITS) +: SLOT_BITS] =
      lane_enabled(k, NARROW_LANES, frame_narrow_w) ? field_k : '0;
  end

  always_ff @(posedge clk_bit or negedge shut_n) begin
    if (!shut_n)     par_q <= '0;
    else if (xfer_w) par_q <= word_next_w;
  end

  serx_clk_gen #(.HIGH_CYC(HIGH_EFF)) u_clk (
    .clk     (clk_bit),
    .rst_n   (shut_n),
    .xfer    (xfer_w),
    .clk_out (clk_out)
  );

  assign par_out = par_q;

endmodule

// File: rtl/serx_chk.sv
module serx_chk #(
  parameter int unsigned WORD_W = 28,
  parameter int unsigned LOW_W  = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer,
  input logic              frame_narrow,
  input logic              clk_out,
  input logic [WORD_W-1:0] par_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  shut_clear_chk: assert property (@(posedge clk)
    (armed && !rst_n) |-> (par_out == '0));

  // R4
  shut_clk_chk: assert property (@(posedge clk)
    (armed && !rst_n) |-> !clk_out);

  // R3
  update_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(par_out) |-> $past(xfer));

  // R5
  clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> clk_out);

  // R5
  fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> $stable(par_out));

  // R6
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_narrow) |=> (par_out[WORD_W-1:LOW_W] == '0));
endmodule

bind serial_frame_expander serx_chk #(
  .WORD_W (WORD_W),
  .LOW_W  (NARROW_W)
) u_chk (
  .clk          (clk_bit),
  .rst_n        (shut_n),
  .xfer         (xfer_w),
  .frame_narrow (frame_narrow_w),
  .clk_out      (clk_out),
  .par_out      (par_out)
);

// File: tb/serial_frame_expander_tb_top.sv
`timescale 1ns/1ps
module serial_frame_expander_tb_top;
  logic        clk_bit = 1'b0;
  logic        shut_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        mode_narrow = 1'b0;
  logic [3:0]  lane_in = 4'h0;
  logic [27:0] par_out;
  logic        clk_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int          pend = 0;
  logic [27:0] exp_q = '0;
  logic [27:0] prev_exp = '0;

  always #5 clk_bit = ~clk_bit;

  serial_frame_expander dut_i (
    .clk_bit     (clk_bit),
    .shut_n      (shut_n),
    .frame_start (frame_start),
    .mode_narrow (mode_narrow),
    .lane_in     (lane_in),
    .par_out     (par_out),
    .clk_out     (clk_out)
  );

  // {narrow, idle gap after slot, word}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 8'd0, 28'h1234567},
    {1'b0, 8'd0, 28'hFEDCBA9},
    {1'b0, 8'd8, 28'h0000001},
    {1'b1, 8'd0, 28'hABCDEF0},
    {1'b0, 8'd8, 28'h8000000},
    {1'b0, 8'd0, 28'h5A5A5A5},
    {1'b1, 8'd8, 28'hFFFFFFF},
    {1'b0, 8'd3, 28'hC3C3C3C}
  };

  // narrow slots keep only the three low lane fields
  function automatic logic [27:0] visible(logic [27:0] w, logic n);
    logic [27:0] v;
    v = w;
    if (n) for (int b = 21; b < 28; b++) v[b] = 1'b0;
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // advance to the next falling edge; check a pending slot load
  task automatic tick();
    @(negedge clk_bit);
    if (pend > 0) begin
      pend--;
      if (pend == 1) begin
        chk(par_out == prev_exp, "R3 word held before load", 32'(par_out), 32'(prev_exp));
        chk(clk_out == 1'b0, "R5 clk low before load", 32'(clk_out), 32'd0);
      end else if (pend == 0) begin
        chk(par_out == exp_q, "R2 word after load", 32'(par_out), 32'(exp_q));
        chk(clk_out == 1'b1, "R5 clk rises with load", 32'(clk_out), 32'd1);
        prev_exp = exp_q;
      end
    end
  endtask

  task automatic send_bits(logic [27:0] w, logic n, int count);
    for (int i = 0; i < count; i++) begin
      tick();
      frame_start = (i == 0);
      mode_narrow = n;
      for (int k = 0; k < 4; k++) lane_in[k] = w[k*7 + i];
    end
    if (count == 7) begin
      exp_q = visible(w, n);
      pend  = 2;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      frame_start = 1'b0;
      lane_in     = 4'hF;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_bit);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 R4: reset state
    repeat (3) @(negedge clk_bit);
    chk(par_out == '0, "R1 reset word", 32'(par_out), 0);
    chk(clk_out == 1'b0, "R4 reset clk", 32'(clk_out), 0);
    shut_n = 1'b1;

    // R2 R6 R9: vector table, back-to-back and gapped slots
    foreach (VEC[j]) begin
      send_bits(VEC[j][27:0], VEC[j][36], 7);
      idle(int'(VEC[j][35:28]));
    end
    idle(3);

    // R5: pulse width and stable word across falling edge
    send_bits(28'h2468ACE, 1'b0, 7);
    idle(2);
    for (int c = 0; c < 3; c++) begin
      tick();
      chk(clk_out == 1'b1, "R5 clk high during pulse", 32'(clk_out), 1);
    end
    tick();
    chk(clk_out == 1'b0, "R5 clk fell after four cycles", 32'(clk_out), 0);
    chk(par_out == 28'h2468ACE, "R5 word stable at fall", 32'(par_out), 32'h2468ACE);

    // R8: restart after three bits
    send_bits(28'hFFFFFFF, 1'b0, 3);
    send_bits(28'h0F0F0F0, 1'b0, 7);
    idle(4);

    // R6: narrow slot with lane 3 busy, then back to four lanes
    send_bits(28'h7F00001, 1'b1, 7);
    send_bits(28'h7654321, 1'b0, 7);
    idle(4);

    // R1 R4 R7: shutdown mid slot
    send_bits(28'h1111111, 1'b0, 3);
    @(negedge clk_bit);
    shut_n = 1'b0;
    #1;
    chk(par_out == '0, "R1 clear on shutdown", 32'(par_out), 0);
    chk(clk_out == 1'b0, "R4 clk off on shutdown", 32'(clk_out), 0);
    pend = 0;
    prev_exp = '0;
    send_bits(28'h3333333, 1'b0, 6);
    chk(clk_out == 1'b0, "R4 clk off during shutdown", 32'(clk_out), 0);
    chk(par_out == '0, "R1 held clear during shutdown", 32'(par_out), 0);
    tick();
    frame_start = 1'b0;
    shut_n = 1'b1;
    idle(6);
    chk(par_out == '0, "R7 zero before first slot", 32'(par_out), 0);
    chk(clk_out == 1'b0, "R7 clk idle before first slot", 32'(clk_out), 0);
    send_bits(28'h0ABCDEF, 1'b0, 7);
    idle(4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule